// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a three-wire serial link to a quad voltage-output DAC. It takes one 16-bit command word at a time through a valid/ready handshake. It shifts the word out most significant bit first on a chip-select, serial-clock and data triple that it generates itself. Every minimum time the converter needs is held as a whole number of system clock cycles: clock high and low widths, chip-select lead and lag around the clock burst, data setup, and the chip-select high time between frames.

The sequencer also tracks the converter's power state. A word whose top four bits are all ones is a power-state command. If its two lowest bits are also zero, it is a wake-up. Once a wake-up frame has been sent, the sequencer holds back every other kind of command until the wake-up recovery interval has elapsed. Further power-state commands still go through at once. While the hold is in force, an output flag reports it.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, ready is high and busy is low.
- R2: Each accepted word produces exactly 16 falling serial clock edges while chip select is low, and the bits on the data line at those edges, taken in order, equal the word with bit 15 first.
- R3: Every serial clock high phase and every low phase between two rising edges of one frame lasts at least HALF_CYC system clock cycles.
- R4: At least LEAD_CYC cycles pass from chip select falling to the first rising serial clock edge, and at least LAG_CYC cycles pass from the last falling edge to chip select rising.
- R5: The data line changes only when chip select falls or when the serial clock rises, never while the clock stays high. It is stable for at least SETUP_CYC cycles before each falling edge.
- R6: Between two frames, chip select stays high for at least GAP_CYC cycles. Ready is low whenever chip select is low.
- R7: After a wake-up word (bits 15..12 = 1111 and bits 1..0 = 00) has been sent, busy is high. A word whose bits 15..12 are not 1111 is not accepted, and its frame does not start, until at least WAKE_CYC cycles after chip select rose at the end of the wake-up frame.
- R8: During the wake-up hold, a word with bits 15..12 = 1111 is accepted as soon as the link is idle and the chip-select gap has passed.
- R9: The serial clock is low whenever chip select is high.
- R10: A word presented with valid high while ready is low is ignored: it produces no frame and does not change the word that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word taken on this cycle if valid is high |
| in_data | input | 16 | Command word: bits 15..12 command, 11..2 data, 1..0 power selection |
| busy | output | 1 | Wake-up recovery hold in force |
| dac_cs_n | output | 1 | Chip select to the converter, active low |
| dac_sclk | output | 1 | Serial clock to the converter, idles low |
| dac_sdo | output | 1 | Serial data to the converter, sampled on the falling clock edge |

## Verification
The handshake checks assume that in_data stays constant while in_valid is high and the word has not yet been taken. Ready depends on whether the offered word is a power-state command, so a word that changed mid-offer would be classified on the wrong value. The stimulus therefore changes valid and data only at falling system clock edges and holds each word until the cycle in which it is accepted. The timing checks also assume every cycle-count parameter is at least one; the bench derives each count by rounding up the nanosecond limit for its 4 ns clock.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int WORD_W   = 16;
  localparam int CMD_W    = 4;
  localparam int SEL_W    = 2;
  localparam logic [CMD_W-1:0] PWR_CMD = '1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_GAP
  } phase_e;

  // Power-state command: top nibble all ones
  function automatic logic is_pwr_cmd(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: CMD_W] == PWR_CMD;
  endfunction

  // Wake-up: power-state command with the selection field cleared
  function automatic logic is_wake_cmd(input logic [WORD_W-1:0] w);
    return is_pwr_cmd(w) && (w[SEL_W-1:0] == '0);
  endfunction
endpackage

// File: rtl/dac_wr_shifter.sv
module dac_wr_shifter
  import dac_wr_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int HALF_CYC = 7,
  parameter int LEAD_CYC = 3,
  parameter int TAIL_CYC = 7,
  parameter int GAP_CYC  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               idle,
  output logic               done,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdo
);
  localparam int M_A   = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
  localparam int M_B   = (TAIL_CYC > GAP_CYC) ? TAIL_CYC : GAP_CYC;
  localparam int MAXC  = (M_A > M_B) ? M_A : M_B;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  phase_e             ph;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   left;
  logic [FRAME_W-1:0] shreg;

  assign idle = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      left  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      sdo   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          ph    <= PH_LEAD;
          cs_n  <= 1'b0;
          sdo   <= word[FRAME_W-1];
          shreg <= {word[FRAME_W-2:0], 1'b0};
          left  <= BIT_W'(FRAME_W - 1);
          cnt   <= CNT_W'(LEAD_CYC - 1);
        end
        PH_LEAD: if (cnt == '0) begin
          ph   <= PH_HIGH;
          sclk <= 1'b1;
          cnt  <= CNT_W'(HALF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt == '0) begin
          ph   <= PH_LOW;
          sclk <= 1'b0;
          cnt  <= (left == '0) ? CNT_W'(TAIL_CYC - 1) : CNT_W'(HALF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt == '0) begin
          if (left == '0) begin
            ph   <= PH_GAP;
            cs_n <= 1'b1;
            done <= 1'b1;
            cnt  <= CNT_W'(GAP_CYC - 1);
          end else begin
            ph    <= PH_HIGH;
            sclk  <= 1'b1;
            sdo   <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            left  <= left - 1'b1;
            cnt   <= CNT_W'(HALF_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        PH_GAP: if (cnt == '0) ph <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R9

  AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo)); // R5
endmodule

// File: rtl/dac_wr_holdoff.sv
module dac_wr_holdoff #(
  parameter int WAKE_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic frame_done,
  output logic hold
);
  localparam int TW = $clog2(WAKE_CYC + 1);

  logic          pend;
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      remain <= '0;
    end else begin
      if (frame_done && pend) begin
        remain <= TW'(WAKE_CYC);
        pend   <= 1'b0;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
      if (arm) pend <= 1'b1;
    end
  end

  assign hold = pend || (remain != '0);

  AST_HOLD_AFTER_WAKE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_done && pend) |=> hold); // R7
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int HALF_CYC = 7,
  parameter int LEAD_CYC = 3,
  parameter int LAG_CYC  = 3,
  parameter int GAP_CYC  = 20,
  parameter int WAKE_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              busy,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo
);
  localparam int TAIL_CYC = (HALF_CYC > LAG_CYC) ? HALF_CYC : LAG_CYC;
  localparam int GW       = $clog2(GAP_CYC + 2);

  logic link_idle, frame_done, hold, accept;

  assign in_ready = link_idle && (!hold || is_pwr_cmd(in_data));
  assign accept   = in_valid && in_ready;
  assign busy     = hold;

  dac_wr_shifter #(
    .FRAME_W (WORD_W),
    .HALF_CYC(HALF_CYC),
    .LEAD_CYC(LEAD_CYC),
    .TAIL_CYC(TAIL_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_shift (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .word (in_data),
    .idle (link_idle),
    .done (frame_done),
    .cs_n (dac_cs_n),
    .sclk (dac_sclk),
    .sdo  (dac_sdo)
  );

  dac_wr_holdoff #(
    .WAKE_CYC(WAKE_CYC)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .arm       (accept && is_wake_cmd(in_data)),
    .frame_done(frame_done),
    .hold      (hold)
  );

  // Length of the current chip-select high run, saturating
  logic [GW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)                  hi_run <= GW'(GAP_CYC);
    else if (!dac_cs_n)       hi_run <= '0;
    else if (hi_run < GW'(GAP_CYC)) hi_run <= hi_run + 1'b1;
  end

  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_cs_n) |-> (hi_run >= GW'(GAP_CYC))); // R6

  AST_READY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> !in_ready); // R6

  AST_HOLD_PASSES_PWR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && busy) |-> (in_data[WORD_W-1 -: CMD_W] == PWR_CMD)); // R8
endmodule

// File: tb/dac_wr_seq_tb.sv
module dac_wr_seq_tb;
  localparam int CLK_NS   = 4;
  localparam int HALF_CYC = (25 + CLK_NS - 1) / CLK_NS;
  localparam int LEAD_CYC = (10 + CLK_NS - 1) / CLK_NS;
  localparam int LAG_CYC  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int SETUP    = (15 + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CYC  = (80 + CLK_NS - 1) / CLK_NS;
  localparam int WAKE_CYC = (8000 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, busy, dac_cs_n, dac_sclk, dac_sdo;

  always #2 clk = ~clk;

  dac_wr_seq #(
    .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC), .LAG_CYC(LAG_CYC),
    .GAP_CYC(GAP_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Link monitor, sampling between edges
  int cyc = 0;
  int frames = 0;
  int nbits = 0, last_bits = 0;
  logic [15:0] cap = '0, last_word = '0;
  int fall_cyc = 0, rise_cyc = 0, last_start = 0;
  int sclk_rise = 0, sclk_fall = 0, sdo_chg = -1000;
  int min_hi = 1000000;
  bit have_rise = 0, first_edge = 0;
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r9 = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !dac_cs_n) begin
        fall_cyc = cyc; nbits = 0; cap = '0; first_edge = 1;
        if (have_rise && (cyc - rise_cyc) < min_hi) min_hi = cyc - rise_cyc;
      end
      if (!p_cs && dac_cs_n) begin
        if (cyc - sclk_fall < LAG_CYC) v_r4++;
        frames++; last_word = cap; last_bits = nbits;
        last_start = fall_cyc; rise_cyc = cyc; have_rise = 1;
      end
      if (!p_sclk && dac_sclk) begin
        if (first_edge) begin
          if (cyc - fall_cyc < LEAD_CYC) v_r4++;
          first_edge = 0;
        end else if (cyc - sclk_fall < HALF_CYC) v_r3++;
        sclk_rise = cyc;
      end
      if (p_sclk && !dac_sclk) begin
        if (cyc - sclk_rise < HALF_CYC) v_r3++;
        if (cyc - sdo_chg < SETUP) v_r5++;
        if (!dac_cs_n) begin cap = {cap[14:0], dac_sdo}; nbits++; end
        sclk_fall = cyc;
      end
      if (dac_sdo !== p_sdo) begin
        if (dac_sclk && p_sclk) v_r5++;
        sdo_chg = cyc;
      end
      if (dac_cs_n && dac_sclk) v_r9++;
    end
    p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdo = dac_sdo;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_data = w; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cs_n", dac_cs_n == 1'b1, dac_cs_n, 1);
    chk("R1 sclk", dac_sclk == 1'b0, dac_sclk, 0);
    chk("R1 ready", in_ready == 1'b1, in_ready, 1);
    chk("R1 busy", busy == 1'b0, busy, 0);
  endtask

  task automatic t_words();
    logic [15:0] pats [5];
    pats = '{16'hA5A4, 16'h0000, 16'hFFFF, 16'h8001, 16'h5AF0};
    for (int i = 0; i < 5; i++) begin
      int f0 = frames;
      send(pats[i]);
      chk("R6 ready low in frame", in_ready == 1'b0 && dac_cs_n == 1'b0, in_ready, 0);
      wait_frames(f0 + 1);
      chk("R2 word", last_word == pats[i], last_word, pats[i]);
      chk("R2 bits", last_bits == 16, last_bits, 16);
      repeat (GAP_CYC + 2) @(negedge clk);
    end
  endtask

  task automatic t_back_to_back();
    int f0 = frames;
    min_hi = 1000000;
    send(16'h1357);
    send(16'h2468);
    wait_frames(f0 + 2);
    chk("R6 gap min", min_hi >= GAP_CYC, min_hi, GAP_CYC);
    chk("R6 gap prompt", min_hi <= GAP_CYC + 2, min_hi, GAP_CYC + 1);
    chk("R2 second word", last_word == 16'h2468, last_word, 16'h2468);
    repeat (GAP_CYC + 2) @(negedge clk);
  endtask

  task automatic t_ignore();
    int f0 = frames;
    bit rdy_seen = 0;
    send(16'h6C3C);
    repeat (3) @(negedge clk);
    in_data = 16'h1234; in_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (in_ready) rdy_seen = 1;
    end
    in_valid = 1'b0;
    repeat (400) @(negedge clk);
    chk("R10 ready low while offered", rdy_seen == 0, rdy_seen, 0);
    chk("R10 one frame", frames == f0 + 1, frames - f0, 1);
    chk("R10 word kept", last_word == 16'h6C3C, last_word, 16'h6C3C);
    chk("R10 link idle", dac_cs_n == 1'b1, dac_cs_n, 1);
  endtask

  task automatic t_wake();
    int f0 = frames, wr, d;
    send(16'hF010);
    wait_frames(f0 + 1);
    wr = rise_cyc;
    @(negedge clk);
    chk("R7 busy set", busy == 1'b1, busy, 1);
    in_data = 16'h4123;
    repeat (GAP_CYC + 5) @(negedge clk);
    chk("R7 data held", in_ready == 1'b0, in_ready, 0);
    send(16'h4123);
    wait_frames(f0 + 2);
    d = last_start - wr;
    chk("R7 holdoff min", d >= WAKE_CYC, d, WAKE_CYC);
    chk("R7 holdoff prompt", d <= WAKE_CYC + 3, d, WAKE_CYC + 2);
    chk("R7 busy clear", busy == 1'b0, busy, 0);
    chk("R2 word after wake", last_word == 16'h4123, last_word, 16'h4123);
    repeat (GAP_CYC + 2) @(negedge clk);
  endtask

  task automatic t_pwr_in_hold();
    int f0 = frames, wr, d;
    send(16'hF010);
    wait_frames(f0 + 1);
    wr = rise_cyc;
    send(16'hF001);
    wait_frames(f0 + 2);
    d = last_start - wr;
    chk("R8 power cmd prompt", d >= GAP_CYC && d <= GAP_CYC + 3, d, GAP_CYC + 1);
    chk("R8 power cmd word", last_word == 16'hF001, last_word, 16'hF001);
    chk("R8 hold remains", busy == 1'b1, busy, 1);
    send(16'h2AB0);
    wait_frames(f0 + 3);
    d = last_start - wr;
    chk("R7 hold not restarted", d >= WAKE_CYC && d <= WAKE_CYC + 3, d, WAKE_CYC + 2);
    repeat (GAP_CYC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_words();
    t_back_to_back();
    t_ignore();
    t_wake();
    t_pwr_in_hold();
    chk("R3 clock widths", v_r3 == 0, v_r3, 0);
    chk("R4 lead and lag", v_r4 == 0, v_r4, 0);
    chk("R5 data setup", v_r5 == 0, v_r5, 0);
    chk("R9 clock idle", v_r9 == 0, v_r9, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule